// File: doc/BRIEF.md
# Write-Only Three-Wire Serial Byte Receiver

This block is a receive-only slave for a three-wire serial bus made of an active-low chip enable, a serial clock and a serial data line. The block has no return line and never drives the bus. Inside the system clock domain it synchronises the three inputs and detects rising serial clock edges. On each of those edges it captures one data bit, and it assembles bytes with the most significant bit first.

Each enabled transfer opens with a header byte. The header carries a write/read flag and a two-bit device select. When the header selects this device for a write, the block passes every following whole byte downstream as a one-cycle strobe. The first of those bytes is flagged as the control byte. In every other case the block discards the rest of the transfer, and it stays silent until chip enable goes inactive. Raising chip enable resets the bit count and the transfer state, and any unfinished byte is thrown away.

Top module: `hdr_serial_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `byteValid` is 0.
- R2: Bits are captured on rising `sclk` edges while `csN` is low, most significant bit first. `byteData` equals the eight bits in the order they were sent.
- R3: After an accepted header, the first complete byte is reported with `byteIsCtrl`=1. Each later byte in the same transfer is reported with `byteIsCtrl`=0.
- R4: If header bits [6:5] are anything other than the `DEV_SEL` parameter (default 2'b01), no byte of that transfer is reported.
- R5: If header bit 7 is 1 (read), no byte of that transfer is reported. A header with bit 7 = 0 is a write.
- R6: Header bits [4:0] do not change which bytes are reported or how they are flagged.
- R7: When `csN` rises, any incomplete byte is discarded and never reported. The next transfer starts again with a header byte on a cleared bit count.
- R8: Each complete byte after the header produces exactly one `byteValid` pulse, and that pulse is one cycle wide.
- R9: While `csN` is high, `sclk` and `sdin` activity produces no `byteValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip enable, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdin | input | 1 | Serial data input |
| byteValid | output | 1 | One-cycle strobe marking a received byte |
| byteData | output | BYTE_W | The received byte, valid while `byteValid` is 1 |
| byteIsCtrl | output | 1 | Marks the strobed byte as the control byte |

## Verification
The bench builds the block with three synchroniser stages instead of the default two. This lengthens the delay from a serial edge to `byteValid` and widens the window after `csN` rises in which a late strobe could leak out. The device select is kept at 2'b01, so the three other select codes and the read flag can all be driven as rejected headers. The byte width stays at 8, which gives the header its fixed flag and select positions. Each serial bit spans many system cycles, so abandoning a transfer after five bits tests the discard of partial bytes.

// File: rtl/hdr_serial_pkg.sv
package hdr_serial_pkg;
  typedef enum logic [1:0] {
    ST_HEADER,
    ST_CTRL,
    ST_DATA,
    ST_DROP
  } rxState_t;

  typedef struct packed {
    logic flush;     // clear bit count and byte state
    logic emit;      // present the assembled byte downstream
    logic emitCtrl;  // the presented byte is the control byte
  } dpStrobe_t;
endpackage

// File: rtl/hdr_serial_dp.sv
module hdr_serial_dp
  import hdr_serial_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csNIn,
  input  logic              sclIn,
  input  logic              sdiIn,
  input  dpStrobe_t         strobe,
  output logic              linkActive,
  output logic              byteReady,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteIsCtrl
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csPipe, sclPipe, sdiPipe;
  logic                   sclPrev;
  logic                   sclRise;
  logic [CNT_W-1:0]       bitCnt;
  logic [BYTE_W-1:0]      shiftReg;

  // all three lines pass through equal-depth synchronisers so data stays aligned with its edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sclPipe <= '0;
      sdiPipe <= '0;
      sclPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_STAGES-2:0], csNIn};
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdiPipe <= {sdiPipe[SYNC_STAGES-2:0], sdiIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
    end
  end

  assign linkActive = ~csPipe[SYNC_STAGES-1];
  assign sclRise    = sclPipe[SYNC_STAGES-1] & ~sclPrev;
  assign rxByte     = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteReady <= 1'b0;
    end else if (strobe.flush) begin
      bitCnt    <= '0;
      byteReady <= 1'b0;
    end else begin
      byteReady <= 1'b0;
      if (sclRise) begin
        shiftReg  <= {shiftReg[BYTE_W-2:0], sdiPipe[SYNC_STAGES-1]};
        bitCnt    <= (bitCnt == LAST_BIT) ? '0 : CNT_W'(bitCnt + 1'b1);
        byteReady <= (bitCnt == LAST_BIT);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteValid  <= 1'b0;
      byteData   <= '0;
      byteIsCtrl <= 1'b0;
    end else begin
      byteValid <= strobe.emit;
      if (strobe.emit) begin
        byteData   <= shiftReg;
        byteIsCtrl <= strobe.emitCtrl;
      end
    end
  end
endmodule

// File: rtl/hdr_serial_ctl.sv
module hdr_serial_ctl
  import hdr_serial_pkg::*;
#(
  parameter int         BYTE_W  = 8,
  parameter logic [1:0] DEV_SEL = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkActive,
  input  logic              byteReady,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         strobe
);
  rxState_t   state, stateNxt;
  logic       readFlag;
  logic [1:0] selField;

  assign readFlag = rxByte[BYTE_W-1];
  assign selField = rxByte[BYTE_W-2 -: 2];

  always_comb begin
    stateNxt     = state;
    strobe       = '0;
    strobe.flush = ~linkActive;
    if (!linkActive) begin
      stateNxt = ST_HEADER;
    end else if (byteReady) begin
      unique case (state)
        ST_HEADER: stateNxt = (!readFlag && selField == DEV_SEL) ? ST_CTRL : ST_DROP;
        ST_CTRL: begin
          strobe.emit     = 1'b1;
          strobe.emitCtrl = 1'b1;
          stateNxt        = ST_DATA;
        end
        ST_DATA:  strobe.emit = 1'b1;
        default:  stateNxt = ST_DROP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HEADER;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/hdr_serial_rx.sv
module hdr_serial_rx
  import hdr_serial_pkg::*;
#(
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] DEV_SEL     = 2'b01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdin,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteIsCtrl
);
  dpStrobe_t         strobe;
  logic              linkActive;
  logic              byteReady;
  logic [BYTE_W-1:0] rxByte;

  hdr_serial_dp #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .csNIn(csN), .sclIn(sclk), .sdiIn(sdin),
    .strobe(strobe), .linkActive(linkActive), .byteReady(byteReady),
    .rxByte(rxByte), .byteValid(byteValid), .byteData(byteData),
    .byteIsCtrl(byteIsCtrl)
  );

  hdr_serial_ctl #(.BYTE_W(BYTE_W), .DEV_SEL(DEV_SEL)) uCtl (
    .clk(clk), .rstN(rstN), .linkActive(linkActive), .byteReady(byteReady),
    .rxByte(rxByte), .strobe(strobe)
  );
endmodule

// File: rtl/hdr_serial_rx_chk.sv
module hdr_serial_rx_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic byteValid,
  input logic byteIsCtrl
);
  localparam logic [4:0] QUIET_LIM = 5'(SYNC_STAGES + 4);

  logic [4:0] idleCnt;
  logic       sawCtrl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      sawCtrl <= 1'b0;
    end else begin
      if (!csN) idleCnt <= '0;
      else if (idleCnt < QUIET_LIM) idleCnt <= idleCnt + 5'd1;
      if (idleCnt >= QUIET_LIM) sawCtrl <= 1'b0;
      else if (byteValid && byteIsCtrl) sawCtrl <= 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rstN |=> !byteValid);
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt >= QUIET_LIM) |-> !byteValid);
  assert_ctrl_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !byteIsCtrl) |-> sawCtrl);
  assert_one_ctrl_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteIsCtrl) |-> !sawCtrl);
endmodule

bind hdr_serial_rx hdr_serial_rx_chk #(.SYNC_STAGES(SYNC_STAGES)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .byteValid(byteValid), .byteIsCtrl(byteIsCtrl)
);

// File: tb/sim_hdr_serial_rx.sv
`timescale 1ns/1ps
module sim_hdr_serial_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic       byteValid;
  logic [7:0] byteData;
  logic       byteIsCtrl;

  int checks = 0;
  int fails = 0;
  int capCount = 0;
  int wideCount = 0;
  logic [7:0] capData [0:15];
  logic       capCtrl [0:15];
  logic       prevValid = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  hdr_serial_rx #(.BYTE_W(8), .SYNC_STAGES(3), .DEV_SEL(2'b01)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdin(sdin),
    .byteValid(byteValid), .byteData(byteData), .byteIsCtrl(byteIsCtrl)
  );

  // capture strobes away from the active edge
  always @(negedge clk) begin
    if (byteValid && prevValid) wideCount++;
    if (byteValid && capCount < 16) begin
      capData[capCount] = byteData;
      capCtrl[capCount] = byteIsCtrl;
    end
    if (byteValid) capCount++;
    prevValid = byteValid;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] value, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdin = value[i];
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
  endtask

  task automatic startXfer;
    capCount = 0;
    csN = 1'b0;
    #50;
  endtask

  task automatic endXfer;
    #100 csN = 1'b1;
    #200;
  endtask

  task automatic checkByte(input int idx, input logic [7:0] exp, input logic expCtrl, input string tag);
    check(capData[idx] == exp, tag, capData[idx], exp);
    check(capCtrl[idx] == expCtrl, "R3 control flag", capCtrl[idx], expCtrl);
  endtask

  task automatic testReset;
    #1;
    check(byteValid == 1'b0, "R1 valid low in reset", byteValid, 0);
  endtask

  task automatic testBasic;
    startXfer();
    sendBits(8'b0010_0000, 8);
    sendBits(8'hA5, 8);
    sendBits(8'h3C, 8);
    sendBits(8'hF0, 8);
    endXfer();
    check(capCount == 3, "R8 byte count basic", capCount, 3);
    checkByte(0, 8'hA5, 1'b1, "R2 control byte value");
    checkByte(1, 8'h3C, 1'b0, "R2 data byte value");
    checkByte(2, 8'hF0, 1'b0, "R2 data byte value");
    check(wideCount == 0, "R8 one-cycle strobe", wideCount, 0);
  endtask

  task automatic testUnusedBits;
    startXfer();
    sendBits(8'b0011_1111, 8);
    sendBits(8'h81, 8);
    sendBits(8'h7E, 8);
    endXfer();
    check(capCount == 2, "R6 low header bits ignored count", capCount, 2);
    checkByte(0, 8'h81, 1'b1, "R6 control byte value");
    checkByte(1, 8'h7E, 1'b0, "R6 data byte value");
  endtask

  task automatic testBadSelect;
    logic [7:0] hdrs [3] = '{8'b0000_0000, 8'b0100_0000, 8'b0110_0000};
    for (int k = 0; k < 3; k++) begin
      startXfer();
      sendBits(hdrs[k], 8);
      sendBits(8'h12, 8);
      sendBits(8'h34, 8);
      endXfer();
      check(capCount == 0, "R4 foreign select dropped", capCount, 0);
    end
  endtask

  task automatic testRead;
    startXfer();
    sendBits(8'b1010_0000, 8);
    sendBits(8'h56, 8);
    sendBits(8'h78, 8);
    endXfer();
    check(capCount == 0, "R5 read header dropped", capCount, 0);
  endtask

  task automatic testPartial;
    startXfer();
    sendBits(8'b0010_0000, 8);
    sendBits(8'h55, 8);
    sendBits(8'hFF, 5);
    endXfer();
    check(capCount == 1, "R7 partial byte discarded", capCount, 1);
    checkByte(0, 8'h55, 1'b1, "R7 byte before partial");
    startXfer();
    sendBits(8'b0010_0000, 8);
    sendBits(8'hC3, 8);
    endXfer();
    check(capCount == 1, "R7 fresh header after partial", capCount, 1);
    checkByte(0, 8'hC3, 1'b1, "R7 realigned byte");
  endtask

  task automatic testIdle;
    capCount = 0;
    sendBits(8'b0010_0000, 8);
    sendBits(8'hAA, 8);
    sendBits(8'h0F, 8);
    #200;
    check(capCount == 0, "R9 no output while disabled", capCount, 0);
  endtask

  initial begin
    testReset();
    #40 rstN = 1'b1;
    #40;
    testBasic();
    testUnusedBits();
    testBadSelect();
    testRead();
    testPartial();
    testIdle();
    check(wideCount == 0, "R8 no wide strobe overall", wideCount, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule